// File: doc/BRIEF.md
# DS3 Alarm and Idle Fill Stage

This block is the last overwrite stage of a DS3 transmit path. It takes a serial bit stream, one bit per clock, and can replace it with an alarm indication signal (AIS) or an idle signal. Framing stays valid while it does so. The M-frame position is tracked inside the block. A one-cycle sync pulse marks the first overhead bit of a multiframe, and between pulses the position counter runs freely through 7 subframes of 8 blocks, each block being 85 bits (one overhead bit and 84 payload bits).

When a fill mode is active, every payload bit is replaced with a fixed pattern, and that pattern restarts after each overhead bit. The alignment bits (F and M) are driven to their fixed values. The X-bits and C-bits follow the rules of the active mode. Both P-bits carry the parity of the payload that was actually sent in the previous multiframe. The enables are sampled only on the first bit of a multiframe, so a frame is never partly filled. When both enables are set, AIS wins. In passthrough mode the block copies its input with one cycle of delay, but it still tracks output parity so that the P-bits are correct in the first filled frame.

Top module: `ds3_alarm_fill`

## Requirements
- R1: With neither enable latched, the output equals the input bit of the previous cycle.
- R2: In AIS mode, payload bit k of each block (k = 0 for the bit right after the overhead bit) is 1 when k is even and 0 when k is odd.
- R3: In idle mode, payload bit k of each block is 1 when k mod 4 is 0 or 1, and 0 otherwise.
- R4: In either fill mode, the F-bits are forced to 1, 0, 0, 1. These sit at block positions 1, 3, 5, 7 of every subframe.
- R5: In either fill mode, the M-bits are forced to 0, 1, 0. These are the first overhead bit of subframes 5, 6, 7.
- R6: In AIS mode, the X-bits are forced to 1, and every C-bit is forced to 0. The X-bits are the first overhead bit of subframes 1 and 2. The C-bits sit at block positions 2, 4, 6.
- R7: In idle mode, the three C-bits of subframe 3 are forced to 0, and the X-bits and all other C-bits pass through unchanged.
- R8: In either fill mode, both P-bits (the first overhead bit of subframes 3 and 4) carry the XOR of all payload bits output in the previous multiframe. Before any frame has completed, that value is 0.
- R9: When both enables are sampled high, the frame is sent in AIS mode.
- R10: The enables are sampled only on the first bit of a multiframe. A change in the middle of a frame has no effect until the next multiframe starts.
- R11: A sync pulse makes its bit the first bit of a multiframe, and it restarts the position count. Without a pulse, the count wraps on its own after 4760 bits.
- R12: While reset is held, the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mf_sync | input | 1 | Marks the current bit as the first bit of a multiframe |
| bit_in | input | 1 | Incoming serial DS3 bit |
| ais_req | input | 1 | AIS fill enable, sampled at multiframe start |
| idle_req | input | 1 | Idle fill enable, sampled at multiframe start |
| bit_out | output | 1 | Outgoing serial DS3 bit, registered |

## Verification
Every output bit is due exactly one clock after the input bit it replaces, because the output register is the only stage in between. The bench drives each bit on a falling edge. On the next falling edge it compares the output against the value its own reference model predicted for that bit. The new enable values decide a frame's mode from its own first bit onward. Parity only shows up in the P-bits one multiframe after the payload it covers, so the frames in the test table are ordered so that the P-bits of one frame carry a known non-zero parity taken from the passthrough frame before it.

// File: rtl/ds3_fill_pkg.sv
package ds3_fill_pkg;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_AIS  = 2'd1,
    MODE_IDLE = 2'd2
  } fill_mode_e;

  // AIS takes priority over idle
  function automatic fill_mode_e pick_mode(input logic ais, input logic idle);
    if (ais)  return MODE_AIS;
    if (idle) return MODE_IDLE;
    return MODE_PASS;
  endfunction

  // payload fill, k counts from 0 right after the overhead bit
  function automatic logic fill_bit(input fill_mode_e m, input int unsigned k);
    if (m == MODE_AIS) return (k % 2) == 0;
    return (k % 4) < 2;
  endfunction

  // overhead value in a fill mode; blk = overhead slot in subframe, sub = subframe
  function automatic logic ovh_bit(input fill_mode_e m, input int unsigned blk,
                                   input int unsigned sub, input logic d, input logic par);
    logic r;
    r = d;
    case (blk)
      1, 7: r = 1'b1;
      3, 5: r = 1'b0;
      2, 4, 6: begin
        if (m == MODE_AIS)  r = 1'b0;
        else if (sub == 2)  r = 1'b0;
      end
      default: begin
        case (sub)
          0, 1: if (m == MODE_AIS) r = 1'b1;
          2, 3: r = par;
          5:    r = 1'b1;
          default: r = 1'b0;
        endcase
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ds3_pos_track.sv
module ds3_pos_track #(
  parameter int BLK_BITS = 85,
  parameter int BLKS     = 8,
  parameter int SUBS     = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sync,
  output logic [$clog2(BLK_BITS)-1:0] bit_idx,
  output logic [$clog2(BLKS)-1:0]     blk_idx,
  output logic [$clog2(SUBS)-1:0]     sub_idx,
  output logic                        at_start
);
  localparam int BW = $clog2(BLK_BITS);
  localparam int KW = $clog2(BLKS);
  localparam int SW = $clog2(SUBS);
  localparam logic [BW-1:0] BIT_LAST = BW'(BLK_BITS - 1);
  localparam logic [KW-1:0] BLK_LAST = KW'(BLKS - 1);
  localparam logic [SW-1:0] SUB_LAST = SW'(SUBS - 1);

  logic [BW-1:0] nxt_bit_q;
  logic [KW-1:0] nxt_blk_q;
  logic [SW-1:0] nxt_sub_q;

  assign bit_idx  = sync ? '0 : nxt_bit_q;
  assign blk_idx  = sync ? '0 : nxt_blk_q;
  assign sub_idx  = sync ? '0 : nxt_sub_q;
  assign at_start = (bit_idx == '0) && (blk_idx == '0) && (sub_idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_bit_q <= '0;
      nxt_blk_q <= '0;
      nxt_sub_q <= '0;
    end else if (bit_idx != BIT_LAST) begin
      nxt_bit_q <= bit_idx + 1'b1;
      nxt_blk_q <= blk_idx;
      nxt_sub_q <= sub_idx;
    end else begin
      nxt_bit_q <= '0;
      if (blk_idx != BLK_LAST) begin
        nxt_blk_q <= blk_idx + 1'b1;
        nxt_sub_q <= sub_idx;
      end else begin
        nxt_blk_q <= '0;
        nxt_sub_q <= (sub_idx == SUB_LAST) ? '0 : sub_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ds3_par_track.sv
module ds3_par_track (
  input  logic clk,
  input  logic rst_n,
  input  logic at_start,
  input  logic is_payload,
  input  logic out_bit,
  output logic prev_par
);
  logic acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= 1'b0;
      prev_par <= 1'b0;
    end else if (at_start) begin
      prev_par <= acc_q;
      acc_q    <= is_payload & out_bit;
    end else if (is_payload) begin
      acc_q    <= acc_q ^ out_bit;
    end
  end
endmodule

// File: rtl/ds3_fill_mux.sv
module ds3_fill_mux import ds3_fill_pkg::*; #(
  parameter int BLK_BITS = 85,
  parameter int BLKS     = 8,
  parameter int SUBS     = 7
) (
  input  fill_mode_e                  mode,
  input  logic [$clog2(BLK_BITS)-1:0] bit_idx,
  input  logic [$clog2(BLKS)-1:0]     blk_idx,
  input  logic [$clog2(SUBS)-1:0]     sub_idx,
  input  logic                        din,
  input  logic                        par,
  output logic                        is_payload,
  output logic                        ovw_bit
);
  assign is_payload = (bit_idx != '0);

  always_comb begin
    if (mode == MODE_PASS)
      ovw_bit = din;
    else if (is_payload)
      ovw_bit = fill_bit(mode, int'(bit_idx) - 1);
    else
      ovw_bit = ovh_bit(mode, int'(blk_idx), int'(sub_idx), din, par);
  end
endmodule

// File: rtl/ds3_alarm_fill.sv
module ds3_alarm_fill import ds3_fill_pkg::*; #(
  parameter int BLK_BITS = 85,
  parameter int BLKS     = 8,
  parameter int SUBS     = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mf_sync,
  input  logic bit_in,
  input  logic ais_req,
  input  logic idle_req,
  output logic bit_out
);
  localparam int BW = $clog2(BLK_BITS);
  localparam int KW = $clog2(BLKS);
  localparam int SW = $clog2(SUBS);

  logic [BW-1:0] bit_idx;
  logic [KW-1:0] blk_idx;
  logic [SW-1:0] sub_idx;
  logic          at_mf_start;
  logic          is_payload;
  logic          ovw_bit;
  logic          prev_par;
  fill_mode_e    mode_q;
  fill_mode_e    cur_mode;

  ds3_pos_track #(.BLK_BITS(BLK_BITS), .BLKS(BLKS), .SUBS(SUBS)) u_pos (
    .clk(clk), .rst_n(rst_n), .sync(mf_sync),
    .bit_idx(bit_idx), .blk_idx(blk_idx), .sub_idx(sub_idx), .at_start(at_mf_start)
  );

  assign cur_mode = at_mf_start ? pick_mode(ais_req, idle_req) : mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_PASS;
    else        mode_q <= cur_mode;
  end

  ds3_fill_mux #(.BLK_BITS(BLK_BITS), .BLKS(BLKS), .SUBS(SUBS)) u_mux (
    .mode(cur_mode), .bit_idx(bit_idx), .blk_idx(blk_idx), .sub_idx(sub_idx),
    .din(bit_in), .par(prev_par), .is_payload(is_payload), .ovw_bit(ovw_bit)
  );

  ds3_par_track u_par (
    .clk(clk), .rst_n(rst_n), .at_start(at_mf_start),
    .is_payload(is_payload), .out_bit(ovw_bit), .prev_par(prev_par)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) bit_out <= 1'b0;
    else        bit_out <= ovw_bit;
  end
endmodule

// File: rtl/ds3_alarm_fill_chk.sv
module ds3_alarm_fill_chk import ds3_fill_pkg::*; #(
  parameter int BLK_BITS = 85,
  parameter int BLKS     = 8,
  parameter int SUBS     = 7
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bit_in,
  input logic                        ais_req,
  input logic                        bit_out,
  input fill_mode_e                  cur_mode,
  input logic                        at_mf_start,
  input logic [$clog2(BLK_BITS)-1:0] bit_idx,
  input logic [$clog2(BLKS)-1:0]     blk_idx,
  input logic [$clog2(SUBS)-1:0]     sub_idx,
  input logic                        prev_par
);
  // R1
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MODE_PASS) |=> bit_out == $past(bit_in));

  // R2
  ais_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MODE_AIS && bit_idx != '0) |=> bit_out == $past(bit_idx[0]));

  // R3
  idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MODE_IDLE && bit_idx != '0) |=> bit_out == $past(bit_idx[1] ^ bit_idx[0]));

  // R4
  f_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != MODE_PASS && bit_idx == '0 && blk_idx[0])
      |=> bit_out == $past(blk_idx == 1 || blk_idx == 7));

  // R5
  m_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != MODE_PASS && bit_idx == '0 && blk_idx == '0 && sub_idx >= 4)
      |=> bit_out == $past(sub_idx == 5));

  // R8
  p_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != MODE_PASS && bit_idx == '0 && blk_idx == '0 && (sub_idx == 2 || sub_idx == 3))
      |=> bit_out == $past(prev_par));

  // R9
  ais_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_mf_start && ais_req) |-> cur_mode == MODE_AIS);
endmodule

bind ds3_alarm_fill ds3_alarm_fill_chk #(.BLK_BITS(BLK_BITS), .BLKS(BLKS), .SUBS(SUBS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .ais_req(ais_req), .bit_out(bit_out),
  .cur_mode(cur_mode), .at_mf_start(at_mf_start), .bit_idx(bit_idx),
  .blk_idx(blk_idx), .sub_idx(sub_idx), .prev_par(prev_par)
);

// File: tb/ds3_alarm_fill_tb.sv
module ds3_alarm_fill_tb;
  localparam int NBIT = 85;
  localparam int NBLK = 8;
  localparam int NSUB = 7;
  localparam int FRAME = NBIT * NBLK * NSUB;
  localparam int NVEC = 12;
  // {ais, idle, kind[1:0] (0 random,1 zeros,2 ones,3 alternating), toggle mid-frame, no sync}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b00_00_00, 6'b10_00_00, 6'b10_00_00, 6'b01_00_00,
    6'b01_10_00, 6'b11_00_00, 6'b00_01_10, 6'b01_00_01,
    6'b10_00_10, 6'b00_00_00, 6'b01_11_00, 6'b00_10_00
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mf_sync = 1'b0, bit_in = 1'b0, ais_req = 1'b0, idle_req = 1'b0;
  logic bit_out;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  // reference model state: position of next bit, latched mode, parity
  int m_b = 0, m_k = 0, m_s = 0, m_mode = 0;
  logic m_acc = 1'b0, m_prev = 1'b0;
  logic pend_v = 1'b0, pend_e = 1'b0;
  string pend_tag = "", tag_ovr = "";

  always #2.5 clk = ~clk;

  ds3_alarm_fill u_dut (.clk(clk), .rst_n(rst_n), .mf_sync(mf_sync), .bit_in(bit_in),
                        .ais_req(ais_req), .idle_req(idle_req), .bit_out(bit_out));

  function automatic logic ref_bit(int mode, int b, int k, int s, logic d, logic pp);
    if (mode == 0) return d;
    if (b > 0) return (mode == 1) ? ((b - 1) % 2 == 0) : ((b - 1) % 4 < 2);
    if (k == 1 || k == 7) return 1'b1;
    if (k == 3 || k == 5) return 1'b0;
    if (k % 2 == 0 && k != 0) return (mode == 1 || s == 2) ? 1'b0 : d;
    if (s <= 1) return (mode == 1) ? 1'b1 : d;
    if (s <= 3) return pp;
    return s == 5;
  endfunction

  function automatic string ref_tag(int mode, int b, int k, int s);
    if (mode == 0) return "R1";
    if (b > 0) return (mode == 1) ? "R2" : "R3";
    if (k % 2 == 1) return "R4";
    if (k != 0) return (mode == 1) ? "R6" : "R7";
    if (s <= 1) return (mode == 1) ? "R6" : "R7";
    if (s <= 3) return "R8";
    return "R5";
  endfunction

  task automatic check(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      if (fails <= 20) $display("FAIL %s: bit_out=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic d, logic s, logic a, logic i);
    logic e;
    @(negedge clk);
    if (pend_v) check(bit_out, pend_e, pend_tag);
    if (s) begin m_b = 0; m_k = 0; m_s = 0; end
    if (m_b == 0 && m_k == 0 && m_s == 0) begin
      m_mode = a ? 1 : (i ? 2 : 0);
      m_prev = m_acc;
      m_acc = 1'b0;
    end
    e = ref_bit(m_mode, m_b, m_k, m_s, d, m_prev);
    if (m_b != 0) m_acc = m_acc ^ e;
    pend_v = 1'b1;
    pend_e = e;
    pend_tag = (tag_ovr != "") ? tag_ovr : ref_tag(m_mode, m_b, m_k, m_s);
    m_b++;
    if (m_b == NBIT) begin
      m_b = 0; m_k++;
      if (m_k == NBLK) begin m_k = 0; m_s = (m_s + 1) % NSUB; end
    end
    mf_sync = s; bit_in = d; ais_req = a; idle_req = i;
  endtask

  function automatic logic next_din(logic [1:0] kind, int n);
    case (kind)
      2'd1: return 1'b0;
      2'd2: return 1'b1;
      2'd3: return n[0];
      default: return lfsr[0];
    endcase
  endfunction

  task automatic run_bits(int n, logic [1:0] kind, logic a, logic i, bit tog, bit nosync);
    for (int n_i = 0; n_i < n; n_i++) begin
      logic ca, ci;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ca = (tog && n_i >= 2000) ? ~a : a;
      ci = (tog && n_i >= 2000) ? ~i : i;
      step(next_din(kind, n_i), (n_i == 0) && !nosync, ca, ci);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R12: output held at 0 during reset, even with live input
    bit_in = 1'b1; ais_req = 1'b1;
    repeat (3) begin @(negedge clk); check(bit_out, 1'b0, "R12"); end
    bit_in = 1'b0; ais_req = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      logic [5:0] w;
      w = VEC[v];
      tag_ovr = (w[5] && w[4]) ? "R9" : (w[1] ? "R10" : (w[0] ? "R11" : ""));
      run_bits(FRAME, w[3:2], w[5], w[4], w[1], w[0]);
    end
    // R11: resync in the middle of a frame, then a full idle frame
    tag_ovr = "R11";
    run_bits(1000, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_bits(FRAME, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    tag_ovr = "";
    run_bits(FRAME, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check(bit_out, pend_e, pend_tag);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule